// File: doc/BRIEF.md
# Character Display Controller Core

This block is the device side of a two-line, sixteen-column character display controller. A host talks to it over an 8-bit parallel port with a register-select line, a read/write line and an enable strobe. Each strobe, when enable falls, carries one of four things. It is an instruction, a status read, a write of one byte into one of the two internal memories, or a read of one byte from them. The memories are an 80-character display RAM and a 64-byte RAM that holds user-defined glyph rows.

One 7-bit address counter serves both memories. After each memory access it steps up or down, as the entry mode selects. Display addresses skip the unused gap between the two line segments. Every accepted command holds the busy flag for a fixed number of system-clock cycles, and strobes that arrive while the flag is set are discarded. The display, cursor and blink enables and the horizontal shift offset come out as plain outputs. A separate lookup port lets a rendering stage fetch rows of user glyphs.

Top module: `chardisp_ctrl`

## Requirements
- R1: The port is decoded as follows. Select=0 with write is an instruction. Select=0 with read is a status read, which returns the busy flag on bit 7 and the address counter on bits 6..0. Select=1 with write stores a RAM byte, and select=1 with read returns one. `host_doe` is 1 only while enable is high with read selected. Out of reset the counter is 0, display RAM is selected, and the display, cursor, blink and shift offset are all 0.
- R2: A command takes effect at the first clock edge that sees enable low after it was high. An instruction is picked by its highest set bit. Bit 0 is clear and bit 1 is home. Bit 2 is entry mode, bit 3 is display control and bit 4 is shift. Bit 5 is the function set, bit 6 sets the glyph-RAM address and bit 7 sets the display-RAM address. A zero byte does nothing.
- R3: Clear fills all 80 display RAM bytes with 0x20. It sets the counter to 0, selects display RAM and sets the shift offset to 0.
- R4: Home sets the counter to 0, selects display RAM and sets the shift offset to 0. No RAM byte changes.
- R5: Clear and home hold busy for LONG_CYC cycles. Every other accepted command holds it for SHORT_CYC cycles. A status read never sets busy.
- R6: While busy is 1, every strobe other than a status read is ignored, so counter, RAM and control outputs are unchanged.
- R7: In an entry-mode byte, bit 1 is the direction (1 = up) and bit 0 enables auto shift. Each RAM read or write steps the counter one place in that direction. With auto shift on, each display-RAM write changes the shift offset modulo 40: by +1 when the direction is up and by -1 when it is down.
- R8: Display addresses wrap per line segment. Stepping up goes 0x27 to 0x40 and 0x67 to 0x00. Stepping down goes 0x40 to 0x27 and 0x00 to 0x67. Glyph-RAM addresses wrap within 6 bits.
- R9: In a display-control byte, bit 2 drives `disp_on`, bit 1 drives `cursor_on` and bit 0 drives `blink_on`.
- R10: In a shift byte, bit 3 chooses the display (1) or the cursor (0), and bit 2 chooses right (1) or left (0). A display shift right takes 1 from the offset and a shift left adds 1, both modulo 40. A cursor move steps the counter up for right and down for left. No RAM byte changes.
- R11: Set glyph-RAM address loads bits 5..0 into the counter and selects glyph RAM. Set display-RAM address loads bits 6..0 and selects display RAM.
- R12: When the upper four bits of `glyph_code` are 0, `glyph_user` is 1 and `glyph_bits` shows bits 4..0 of the glyph-RAM byte at address {code[2:0], row}. Otherwise both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rs | input | 1 | Register select: 0 instruction/status, 1 RAM data |
| host_rw | input | 1 | 1 read, 0 write |
| host_en | input | 1 | Enable strobe, committed on its falling edge |
| host_din | input | 8 | Byte from host |
| host_dout | output | 8 | Byte to host, valid while `host_doe` |
| host_doe | output | 1 | Data bus drive enable |
| glyph_code | input | 8 | Character code for glyph lookup |
| glyph_row | input | 3 | Row index for glyph lookup |
| glyph_bits | output | 5 | Row pixels of a user glyph |
| glyph_user | output | 1 | Code selects a user glyph |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| shift_ofs | output | 6 | Display shift offset, 0..39 |

## Verification
The assertions assume that select, read/write and the data byte stay steady through the clock edge that sees enable fall. They also assume that enable stays high for at least one clock edge, and that the host only sets display addresses inside the two 40-character segments. The bench's bus task holds every line for a full cycle on both sides of each strobe. Random display addresses are drawn only from the valid column range, and cursor moves can only reach valid addresses because they use the segment wrap.

// File: rtl/chardisp_pkg.sv
// Shared types and helpers for the character display controller.
// Assumes a 7-bit address counter whose bit 6 marks the second line segment.
package chardisp_pkg;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP, OP_SHIFT, OP_FUNC,
        OP_SET_CG, OP_SET_DD, OP_STATUS, OP_WRITE, OP_READ
    } op_e;

    // Classify one bus transfer; instructions by the highest set bit.
    function automatic op_e decode_op(input logic rs, input logic rw, input logic [7:0] b);
        op_e r;
        if (rs) begin
            r = rw ? OP_READ : OP_WRITE;
        end else if (rw) begin
            r = OP_STATUS;
        end else begin
            casez (b)
                8'b1???????: r = OP_SET_DD;
                8'b01??????: r = OP_SET_CG;
                8'b001?????: r = OP_FUNC;
                8'b0001????: r = OP_SHIFT;
                8'b00001???: r = OP_DISP;
                8'b000001??: r = OP_ENTRY;
                8'b0000001?: r = OP_HOME;
                8'b00000001: r = OP_CLEAR;
                default:     r = OP_NONE;
            endcase
        end
        return r;
    endfunction

    // Next counter value; display addresses wrap per segment, glyph ones in 6 bits.
    function automatic logic [6:0] ac_step(input logic [6:0] ac, input logic up,
                                           input logic cg, input logic [6:0] last_lo);
        logic [6:0] last_hi;
        last_hi = last_lo | 7'h40;
        if (cg) return {1'b0, up ? ac[5:0] + 6'd1 : ac[5:0] - 6'd1};
        if (up) begin
            if (ac == last_lo) return 7'h40;
            if (ac == last_hi) return 7'h00;
            return ac + 7'd1;
        end
        if (ac == 7'h00) return last_hi;
        if (ac == 7'h40) return last_lo;
        return ac - 7'd1;
    endfunction

endpackage

// File: rtl/chardisp_bus_if.sv
// Host strobe front end: finds the falling edge of enable and qualifies the command.
// Assumes select, read/write and data are steady at the edge that sees enable low.
module chardisp_bus_if
    import chardisp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rs,
    input  logic       bus_rw,
    input  logic       bus_en,
    input  logic [7:0] bus_d,
    input  logic       busy,
    output logic       cmd_fire,
    output op_e        cmd_op,
    output logic [7:0] cmd_arg
);
    logic en_q;

    // Remember the previous enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= bus_en;
    end

    // Decode and gate: status reads and empty bytes never start an operation.
    always_comb begin
        cmd_op   = decode_op(bus_rs, bus_rw, bus_d);
        cmd_arg  = bus_d;
        cmd_fire = en_q && !bus_en && !busy &&
                   (cmd_op != OP_STATUS) && (cmd_op != OP_NONE);
    end
endmodule

// File: rtl/chardisp_busy_timer.sv
// Execution timer: holds busy for a long or short cycle count after each command.
// Assumes LONG_CYC >= SHORT_CYC >= 1.
module chardisp_busy_timer #(
    parameter int LONG_CYC  = 76000,
    parameter int SHORT_CYC = 1850
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    output logic busy
);
    localparam int CW = $clog2(LONG_CYC + 1);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (start)    cnt <= long_op ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        else if (cnt != 0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/chardisp_ram.sv
// Display RAM and glyph RAM with a host port and a glyph lookup port.
// Assumes display addresses with bits 5..0 beyond the segment length are unused.
module chardisp_ram #(
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       we,
    input  logic       sel_cg,
    input  logic [6:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [$clog2(CG_DEPTH)-1:0] gaddr,
    output logic [7:0] gdata
);
    localparam int LINE_LEN = DD_DEPTH / 2;
    localparam int DIW      = $clog2(DD_DEPTH);
    localparam int CAW      = $clog2(CG_DEPTH);
    localparam logic [7:0] BLANK = 8'h20;

    logic [7:0] dd_mem [DD_DEPTH];
    logic [7:0] cg_mem [CG_DEPTH];
    logic [DIW-1:0] dd_idx;
    logic dd_ok;
    logic [DD_DEPTH-1:0] dd_we;
    logic [CG_DEPTH-1:0] cg_we;
    logic unused_addr;

    // Map segment address to a flat display index.
    always_comb begin
        dd_ok  = (addr[5:0] < 6'(LINE_LEN));
        dd_idx = addr[6] ? DIW'(LINE_LEN) + DIW'(addr[5:0]) : DIW'(addr[5:0]);
    end
    assign unused_addr = addr[6] & (CAW < 6 ? addr[5] : 1'b0);

    // Per-cell write enables.
    for (genvar i = 0; i < DD_DEPTH; i++) begin : g_dd_we
        assign dd_we[i] = we && !sel_cg && dd_ok && (dd_idx == DIW'(i));
    end
    for (genvar j = 0; j < CG_DEPTH; j++) begin : g_cg_we
        assign cg_we[j] = we && sel_cg && (addr[CAW-1:0] == CAW'(j));
    end

    // Display RAM: blank on reset and on clear, else host writes.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DD_DEPTH; i++) begin
            if (!rst_n || clr) dd_mem[i] <= BLANK;
            else if (dd_we[i]) dd_mem[i] <= wdata;
        end
    end

    // Glyph RAM: zero on reset, else host writes.
    always_ff @(posedge clk) begin
        for (int j = 0; j < CG_DEPTH; j++) begin
            if (!rst_n)        cg_mem[j] <= 8'h00;
            else if (cg_we[j]) cg_mem[j] <= wdata;
        end
    end

    // Host read mux and glyph lookup.
    always_comb begin
        if (sel_cg)     rdata = cg_mem[addr[CAW-1:0]];
        else if (dd_ok) rdata = dd_mem[dd_idx];
        else            rdata = BLANK;
        gdata = cg_mem[gaddr];
    end
endmodule

// File: rtl/chardisp_ctrl.sv
// Top of the character display controller: address counter, mode state,
// bus read mux and glyph port. Assumes host lines are synchronous to clk.
module chardisp_ctrl
    import chardisp_pkg::*;
#(
    parameter int DD_DEPTH  = 80,
    parameter int CG_DEPTH  = 64,
    parameter int LONG_CYC  = 76000,
    parameter int SHORT_CYC = 1850
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rs,
    input  logic       host_rw,
    input  logic       host_en,
    input  logic [7:0] host_din,
    output logic [7:0] host_dout,
    output logic       host_doe,
    input  logic [7:0] glyph_code,
    input  logic [2:0] glyph_row,
    output logic [4:0] glyph_bits,
    output logic       glyph_user,
    output logic       disp_on,
    output logic       cursor_on,
    output logic       blink_on,
    output logic [$clog2(DD_DEPTH/2)-1:0] shift_ofs
);
    localparam int LINE_LEN = DD_DEPTH / 2;
    localparam int OFS_W    = $clog2(LINE_LEN);
    localparam int CAW      = $clog2(CG_DEPTH);
    localparam logic [6:0] LAST_LO = 7'(LINE_LEN - 1);

    logic       cmd_fire, busy;
    op_e        cmd_op;
    logic [7:0] cmd_arg;
    logic [6:0] ac;
    logic       sel_cg, inc_dir, auto_shift;
    logic [OFS_W-1:0] ofs_up, ofs_dn;
    logic [7:0] ram_rdata, ram_gdata;
    logic       unused_bits;

    chardisp_bus_if u_bus (
        .clk(clk), .rst_n(rst_n), .bus_rs(host_rs), .bus_rw(host_rw),
        .bus_en(host_en), .bus_d(host_din), .busy(busy),
        .cmd_fire(cmd_fire), .cmd_op(cmd_op), .cmd_arg(cmd_arg)
    );

    chardisp_busy_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(cmd_fire),
        .long_op(cmd_op == OP_CLEAR || cmd_op == OP_HOME), .busy(busy)
    );

    chardisp_ram #(.DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .clr(cmd_fire && cmd_op == OP_CLEAR),
        .we(cmd_fire && cmd_op == OP_WRITE),
        .sel_cg(sel_cg), .addr(ac), .wdata(cmd_arg), .rdata(ram_rdata),
        .gaddr(CAW'({glyph_code[2:0], glyph_row})), .gdata(ram_gdata)
    );

    // Shift offset neighbours, modulo the segment length.
    always_comb begin
        ofs_up = (shift_ofs == OFS_W'(LINE_LEN - 1)) ? '0 : shift_ofs + 1'b1;
        ofs_dn = (shift_ofs == '0) ? OFS_W'(LINE_LEN - 1) : shift_ofs - 1'b1;
    end

    // Command execution: counter, memory select, entry mode, display flags, shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0; sel_cg <= 1'b0; inc_dir <= 1'b1; auto_shift <= 1'b0;
            disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0; shift_ofs <= '0;
        end else if (cmd_fire) begin
            case (cmd_op)
                OP_CLEAR, OP_HOME: begin
                    ac <= '0; sel_cg <= 1'b0; shift_ofs <= '0;
                end
                OP_ENTRY: begin
                    inc_dir <= cmd_arg[1]; auto_shift <= cmd_arg[0];
                end
                OP_DISP: begin
                    disp_on <= cmd_arg[2]; cursor_on <= cmd_arg[1]; blink_on <= cmd_arg[0];
                end
                OP_SHIFT: begin
                    if (cmd_arg[3]) shift_ofs <= cmd_arg[2] ? ofs_dn : ofs_up;
                    else            ac <= ac_step(ac, cmd_arg[2], sel_cg, LAST_LO);
                end
                OP_SET_CG: begin
                    ac <= {1'b0, cmd_arg[5:0]}; sel_cg <= 1'b1;
                end
                OP_SET_DD: begin
                    ac <= cmd_arg[6:0]; sel_cg <= 1'b0;
                end
                OP_WRITE: begin
                    ac <= ac_step(ac, inc_dir, sel_cg, LAST_LO);
                    if (!sel_cg && auto_shift) shift_ofs <= inc_dir ? ofs_up : ofs_dn;
                end
                OP_READ: ac <= ac_step(ac, inc_dir, sel_cg, LAST_LO);
                default: ;
            endcase
        end
    end

    // Bus read mux and glyph output.
    always_comb begin
        host_doe   = host_en && host_rw;
        host_dout  = !host_doe ? 8'h00 : (host_rs ? ram_rdata : {busy, ac});
        glyph_user = (glyph_code[7:4] == 4'h0);
        glyph_bits = glyph_user ? ram_gdata[4:0] : 5'h00;
    end

    assign unused_bits = ram_gdata[7] ^ ram_gdata[6] ^ ram_gdata[5] ^ glyph_code[3];
endmodule

// File: rtl/chardisp_checker.sv
// Protocol checks for the controller, bound to every instance of the top.
module chardisp_checker
    import chardisp_pkg::*;
#(
    parameter int LINE_LEN = 40,
    parameter int OFS_W    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_fire,
    input op_e              cmd_op,
    input logic             busy,
    input logic [6:0]       ac,
    input logic             sel_cg,
    input logic             inc_dir,
    input logic [OFS_W-1:0] ofs
);
    assert_busy_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> busy);

    assert_ignore_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ac) && $stable(ofs) && $stable(sel_cg)));

    assert_clear_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_CLEAR) |=> (ac == 7'h00 && ofs == '0 && !sel_cg));

    assert_home_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_HOME) |=> (ac == 7'h00 && ofs == '0));

    assert_wrap_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_WRITE && !sel_cg && inc_dir && ac == 7'(LINE_LEN - 1))
        |=> ac == 7'h40);

    assert_wrap_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_op == OP_WRITE && !sel_cg && !inc_dir && ac == 7'h00)
        |=> ac == (7'h40 | 7'(LINE_LEN - 1)));

    assert_ofs_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ofs < OFS_W'(LINE_LEN));
endmodule

bind chardisp_ctrl chardisp_checker #(.LINE_LEN(LINE_LEN), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_fire(cmd_fire), .cmd_op(cmd_op), .busy(busy),
    .ac(ac), .sel_cg(sel_cg), .inc_dir(inc_dir), .ofs(shift_ofs)
);

// File: tb/chardisp_ctrl_tb.sv
module chardisp_ctrl_tb;
    localparam int LONG_T = 40, SHORT_T = 8, LINE = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, host_rs, host_rw, host_en, host_doe, glyph_user;
    logic disp_on, cursor_on, blink_on;
    logic [7:0] host_din, host_dout, glyph_code;
    logic [2:0] glyph_row;
    logic [4:0] glyph_bits;
    logic [5:0] shift_ofs;

    chardisp_ctrl #(.LONG_CYC(LONG_T), .SHORT_CYC(SHORT_T)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_rs(host_rs), .host_rw(host_rw),
        .host_en(host_en), .host_din(host_din), .host_dout(host_dout),
        .host_doe(host_doe), .glyph_code(glyph_code), .glyph_row(glyph_row),
        .glyph_bits(glyph_bits), .glyph_user(glyph_user), .disp_on(disp_on),
        .cursor_on(cursor_on), .blink_on(blink_on), .shift_ofs(shift_ofs)
    );

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [7:0] m_dd [80];
    logic [7:0] m_cg [64];
    logic [6:0] m_ac;
    bit m_sel_cg, m_inc, m_sh, m_d, m_c, m_b;
    int m_ofs;

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Model of the counter step (flat position on an 80-slot ring for display RAM).
    function automatic logic [6:0] m_step(logic [6:0] a, bit up, bit cg);
        int pos;
        if (cg) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
        pos = (a[6] ? LINE : 0) + int'(a[5:0]);
        pos = (pos + (up ? 1 : 79)) % 80;
        return (pos >= LINE) ? 7'(64 + pos - LINE) : 7'(pos);
    endfunction

    function automatic int m_idx(logic [6:0] a);
        return (a[6] ? LINE : 0) + int'(a[5:0]);
    endfunction

    task automatic bus(input bit rs, input bit rw, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk); host_rs = rs; host_rw = rw; host_din = d;
        @(negedge clk); host_en = 1'b1;
        @(negedge clk);
        @(negedge clk); q = host_dout;
        host_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic status(output bit b, output logic [6:0] a);
        logic [7:0] q;
        bus(1'b0, 1'b1, 8'h00, q);
        b = q[7]; a = q[6:0];
    endtask

    // Poll until ready, then compare counter and shift offset with the model.
    task automatic wait_ready(string tag);
        bit b; logic [6:0] a;
        for (int i = 0; i < 100; i++) begin
            status(b, a);
            if (!b) break;
        end
        check_eq({tag, " busy"}, int'(b), 0);
        check_eq({tag, " counter"}, int'(a), int'(m_ac));
        check_eq({tag, " shift"}, int'(shift_ofs), m_ofs);
    endtask

    task automatic m_ofs_move(bit up);
        m_ofs = up ? (m_ofs + 1) % LINE : (m_ofs + LINE - 1) % LINE;
    endtask

    task automatic op_instr(logic [7:0] d);
        logic [7:0] q;
        bus(1'b0, 1'b0, d, q);
        if (d[7]) begin m_ac = d[6:0]; m_sel_cg = 0; end
        else if (d[6]) begin m_ac = {1'b0, d[5:0]}; m_sel_cg = 1; end
        else if (d[5]) ;
        else if (d[4]) begin
            if (d[3]) m_ofs_move(!d[2]);
            else m_ac = m_step(m_ac, d[2], m_sel_cg);
        end
        else if (d[3]) begin m_d = d[2]; m_c = d[1]; m_b = d[0]; end
        else if (d[2]) begin m_inc = d[1]; m_sh = d[0]; end
        else if (d[1]) begin m_ac = 0; m_ofs = 0; m_sel_cg = 0; end
        else if (d[0]) begin
            for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
            m_ac = 0; m_ofs = 0; m_sel_cg = 0;
        end
        wait_ready("R2 instr");
    endtask

    task automatic op_write(logic [7:0] d);
        logic [7:0] q;
        bus(1'b1, 1'b0, d, q);
        if (m_sel_cg) m_cg[m_ac[5:0]] = d;
        else begin
            m_dd[m_idx(m_ac)] = d;
            if (m_sh) m_ofs_move(m_inc);
        end
        m_ac = m_step(m_ac, m_inc, m_sel_cg);
        wait_ready("R7 write");
    endtask

    task automatic op_read(string tag);
        logic [7:0] q;
        int exp;
        exp = m_sel_cg ? int'(m_cg[m_ac[5:0]]) : int'(m_dd[m_idx(m_ac)]);
        bus(1'b1, 1'b1, 8'h00, q);
        check_eq(tag, int'(q), exp);
        m_ac = m_step(m_ac, m_inc, m_sel_cg);
        wait_ready("R7 read");
    endtask

    task automatic sweep(string tag);
        op_instr(8'h06);
        op_instr(8'h80);
        for (int i = 0; i < 80; i++) op_read(tag);
    endtask

    task automatic flags_check(string tag);
        check_eq({tag, " disp"}, int'(disp_on), int'(m_d));
        check_eq({tag, " cursor"}, int'(cursor_on), int'(m_c));
        check_eq({tag, " blink"}, int'(blink_on), int'(m_b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [7:0] q;
        bit b; logic [6:0] a;
        void'($urandom(32'd20241));
        rst_n = 0; host_rs = 0; host_rw = 0; host_en = 0; host_din = 0;
        glyph_code = 0; glyph_row = 0;
        for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
        for (int i = 0; i < 64; i++) m_cg[i] = 8'h00;
        m_ac = 0; m_sel_cg = 0; m_inc = 1; m_sh = 0; m_d = 0; m_c = 0; m_b = 0; m_ofs = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state and bus drive
        check_eq("R1 reset doe", int'(host_doe), 0);
        flags_check("R1 reset");
        check_eq("R1 reset shift", int'(shift_ofs), 0);
        status(b, a);
        check_eq("R1 reset status", int'({b, a}), 0);
        host_rs = 0; host_rw = 1; host_din = 0;
        @(negedge clk); host_en = 1; #1;
        check_eq("R1 doe on read", int'(host_doe), 1);
        @(negedge clk); host_en = 0; host_rw = 0;
        @(negedge clk); host_en = 1; #1;
        check_eq("R1 doe off on write", int'(host_doe), 0);
        @(negedge clk); host_en = 0;
        @(negedge clk);
        wait_ready("R2 zero byte");

        // R9 display control, R2 function set accepted
        op_instr(8'h38);
        op_instr(8'h06);
        op_instr(8'h0F);
        flags_check("R9 all on");
        op_instr(8'h0C);
        flags_check("R9 cursor off");

        // R5 busy timing
        bus(1'b0, 1'b0, 8'h0E, q); m_c = 1;
        status(b, a);
        check_eq("R5 short busy", int'(b), 1);
        repeat (SHORT_T) @(negedge clk);
        status(b, a);
        check_eq("R5 short done", int'(b), 0);
        bus(1'b0, 1'b0, 8'h01, q);
        status(b, a);
        check_eq("R5 long busy", int'(b), 1);
        repeat (SHORT_T + 4) @(negedge clk);
        status(b, a);
        check_eq("R5 long still busy", int'(b), 1);
        repeat (LONG_T) @(negedge clk);
        status(b, a);
        check_eq("R5 long done", int'(b), 0);
        check_eq("R3 counter after clear", int'(a), 0);

        // R6 strobes ignored while busy
        bus(1'b0, 1'b0, 8'h85, q); m_ac = 7'h05;
        bus(1'b0, 1'b0, 8'h08, q);
        wait_ready("R6 instr ignored");
        flags_check("R6 instr ignored");
        bus(1'b1, 1'b0, 8'h41, q); m_dd[5] = 8'h41; m_ac = 7'h06;
        bus(1'b1, 1'b0, 8'h42, q);
        wait_ready("R6 write ignored");
        op_instr(8'h85);
        op_read("R6 ram kept");
        op_read("R6 ram untouched");

        // R10 shift and cursor move, R4 home
        op_instr(8'h18);
        check_eq("R10 shift left", int'(shift_ofs), 1);
        op_instr(8'h14);
        op_instr(8'h10);
        op_instr(8'h1C);
        op_instr(8'h1C);
        check_eq("R10 shift right wrap", int'(shift_ofs), 39);
        op_instr(8'h02);
        check_eq("R4 home shift", int'(shift_ofs), 0);
        op_instr(8'h85);
        op_read("R4 ram unchanged");

        // R8 wraps both directions, glyph RAM 6-bit wrap
        op_instr(8'hA7); op_write(8'h31);
        check_eq("R8 0x27 up", int'(m_ac), 'h40);
        op_instr(8'hE7); op_write(8'h32);
        check_eq("R8 0x67 up", int'(m_ac), 'h00);
        op_instr(8'h04);
        op_instr(8'hC0); op_write(8'h33);
        op_instr(8'h80); op_write(8'h34);
        op_instr(8'h06);
        op_instr(8'h7F); op_write(8'h1F);

        // R7 auto shift both directions
        op_instr(8'h07); op_instr(8'h90); op_write(8'h51);
        check_eq("R7 auto shift up", int'(shift_ofs), 1);
        op_instr(8'h05); op_write(8'h52);
        check_eq("R7 auto shift down", int'(shift_ofs), 0);
        op_instr(8'h06);

        // R11 and R12 glyph lookup
        op_instr(8'h5D); op_write(8'h15);
        @(negedge clk); glyph_code = 8'h03; glyph_row = 3'd5; #1;
        check_eq("R12 user bits", int'(glyph_bits), 'h15);
        check_eq("R12 user flag", int'(glyph_user), 1);
        glyph_code = 8'h0B; #1;
        check_eq("R12 alias bits", int'(glyph_bits), 'h15);
        glyph_code = 8'h13; #1;
        check_eq("R12 rom flag", int'(glyph_user), 0);
        check_eq("R12 rom bits", int'(glyph_bits), 0);
        op_instr(8'h5D);
        op_read("R11 glyph readback");

        // R3 clear wipes display RAM
        op_instr(8'h01);
        sweep("R3 blank after clear");

        // Random mix
        for (int n = 0; n < 300; n++) begin
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0, 1, 2: op_write(8'($urandom_range(0, 255)));
                3, 4:    op_read("R7 random read");
                5: op_instr(8'h80 | 8'($urandom_range(0, 1) * 64 + $urandom_range(0, LINE - 1)));
                6: op_instr(8'h40 | 8'($urandom_range(0, 63)));
                7: op_instr(8'h04 | 8'($urandom_range(0, 3)));
                8: op_instr(8'h10 | 8'($urandom_range(0, 3) << 2));
                default: begin
                    op_instr(8'h08 | 8'($urandom_range(0, 7)));
                    flags_check("R9 random");
                end
            endcase
        end
        sweep("R8 random final sweep");
        summary();
    end
endmodule